// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns one 32-bit instruction word into the full set of control points for a single-cycle integer datapath. It reads the major opcode, the three-bit function field and the seven-bit function field, and it folds in the two flags from an external branch comparator (operands equal, operand A less than operand B). From these it selects the next-PC source, the immediate format, the register write enable, both ALU operand sources, the ALU operation, the comparator signedness, the data-memory direction and the write-back source.

The decoder is purely combinational. Every output is a function of the present inputs only. The instruction completes in the same cycle, so there is no stream traffic and no handshake: all pins are plain control levels. The supported set is register-register and register-immediate arithmetic, word load and word store, the six conditional branches, the two jumps, and the two upper-immediate instructions. Any other encoding yields a safe setting that neither writes a register nor stores to memory.

Top module: `rvdec_ctrl`

## Requirements
- R1: Opcode 0110011 with funct7 0000000 (any funct3), or with funct7 0100000 and funct3 000 or 101, gives reg_we=1, b_sel=0, a_sel=0, mem_wr=0, wb_sel=1, pc_sel=0, imm_sel=0, br_un=0, and alu_sel from R2.
- R2: ALU codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9, PASSB=10. funct3 maps as 000 ADD (SUB when funct7 bit 5 is set on the register form only), 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL (SRA when funct7 bit 5 is set), 110 OR, 111 AND.
- R3: Opcode 0010011 gives imm_sel=0 (I), b_sel=1, reg_we=1, wb_sel=1, a_sel=0, mem_wr=0, pc_sel=0, br_un=0, and alu_sel from R2. Funct3 001 needs funct7 0000000, and funct3 101 needs 0000000 or 0100000. Otherwise the encoding is illegal.
- R4: Opcode 0000011 with funct3 010 gives imm_sel=0, b_sel=1, alu_sel=ADD, reg_we=1, wb_sel=0 (memory), mem_wr=0, a_sel=0, pc_sel=0, br_un=0.
- R5: Opcode 0100011 with funct3 010 gives imm_sel=1 (S), b_sel=1, alu_sel=ADD, mem_wr=1, reg_we=0, wb_sel=1, a_sel=0, pc_sel=0, br_un=0.
- R6: Opcode 1100011 with funct3 other than 010 or 011 gives imm_sel=2 (B), a_sel=1, b_sel=1, alu_sel=ADD, reg_we=0, mem_wr=0, wb_sel=1.
- R7: For a branch, pc_sel=1 (ALU target) exactly when the condition holds: funct3 000 on br_eq, 001 on not br_eq, 100 and 110 on br_lt, 101 and 111 on not br_lt. Otherwise pc_sel=0 (PC+4).
- R8: br_un=1 only for branch funct3 110 and 111. It is 0 for every other instruction.
- R9: Opcode 1101111 gives imm_sel=4 (J), a_sel=1, b_sel=1, alu_sel=ADD, reg_we=1, wb_sel=2 (PC+4), pc_sel=1, mem_wr=0, br_un=0, regardless of the comparator flags.
- R10: Opcode 1100111 with funct3 000 gives imm_sel=0, a_sel=0, b_sel=1, alu_sel=ADD, reg_we=1, wb_sel=2, pc_sel=1, mem_wr=0, br_un=0.
- R11: Opcode 0110111 gives imm_sel=3 (U), a_sel=0, b_sel=1, alu_sel=PASSB, reg_we=1, wb_sel=1, pc_sel=0, mem_wr=0, br_un=0.
- R12: Opcode 0010111 gives imm_sel=3, a_sel=1, b_sel=1, alu_sel=ADD, reg_we=1, wb_sel=1, pc_sel=0, mem_wr=0, br_un=0.
- R13: Any other encoding drives every output to 0: no register write, a memory read, PC+4, and all selects at code 0.
- R14: Outputs follow input changes with no clock edge. A change on br_eq or br_lt alone moves pc_sel within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word being executed |
| br_eq | input | 1 | Comparator: operands equal |
| br_lt | input | 1 | Comparator: operand A less than operand B |
| pc_sel | output | 1 | 0 = PC+4, 1 = ALU result |
| imm_sel | output | 3 | Immediate format: I=0, S=1, B=2, U=3, J=4 |
| reg_we | output | 1 | Register file write enable |
| a_sel | output | 1 | 0 = rs1, 1 = PC |
| b_sel | output | 1 | 0 = rs2, 1 = immediate |
| alu_sel | output | 4 | ALU operation code (R2) |
| br_un | output | 1 | Comparator uses unsigned order |
| mem_wr | output | 1 | 1 = store, 0 = read |
| wb_sel | output | 2 | Write-back: 0 = memory, 1 = ALU, 2 = PC+4 |

## Verification
The bench targets the funct7 gate on shifts and subtract. A decoder that ignored it would turn an immediate add with bit 30 set into a subtract, or accept a malformed shift instead of making it safe. It sweeps all six branch conditions against all four flag combinations. There an inverted sense or a swapped signed/unsigned pair shows up as a wrong pc_sel or br_un. Branch funct3 010 and 011, non-word loads and stores, jalr with non-zero funct3, and random opcodes must all collapse to the all-zero safe vector. A design that leaked a register write or a store there would corrupt state.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int INSN_W    = 32;
  localparam int OPC_W     = 7;
  localparam int F3_W      = 3;
  localparam int F7_W      = 7;
  localparam int ALU_SEL_W = 4;
  localparam int IMM_SEL_W = 3;
  localparam int WB_SEL_W  = 2;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;
  localparam logic [F3_W-1:0] F3_WORD = 3'b010;

  typedef enum logic [IMM_SEL_W-1:0] {
    IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
  } imm_sel_e;

  typedef enum logic [ALU_SEL_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR = 4'd8, ALU_AND = 4'd9, ALU_PASSB = 4'd10
  } alu_sel_e;

  typedef enum logic [WB_SEL_W-1:0] {
    WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC4 = 2'd2
  } wb_sel_e;

  typedef enum logic [3:0] {
    CL_ILLEGAL, CL_REG, CL_IMM, CL_LOAD, CL_STORE,
    CL_BRANCH, CL_JAL, CL_JALR, CL_LUI, CL_AUIPC
  } insn_class_e;

  typedef struct packed {
    logic     pc_alu;
    imm_sel_e imm;
    logic     reg_we;
    logic     a_pc;
    logic     b_imm;
    alu_sel_e alu;
    logic     br_un;
    logic     mem_wr;
    wb_sel_e  wb;
  } ctrl_t;

  localparam ctrl_t CTRL_SAFE = '{
    pc_alu: 1'b0, imm: IMM_I, reg_we: 1'b0, a_pc: 1'b0, b_imm: 1'b0,
    alu: ALU_ADD, br_un: 1'b0, mem_wr: 1'b0, wb: WB_MEM
  };
endpackage

// File: rtl/rvdec_class.sv
module rvdec_class
  import rvdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [F3_W-1:0]  funct3,
  input  logic [F7_W-1:0]  funct7,
  output insn_class_e      cls
);
  logic f7_base, f7_alt;
  assign f7_base = (funct7 == F7_BASE);
  assign f7_alt  = (funct7 == F7_ALT);

  always_comb begin
    cls = CL_ILLEGAL;
    case (opcode)
      OPC_REG: begin
        if (f7_base || (f7_alt && (funct3 == 3'b000 || funct3 == 3'b101)))
          cls = CL_REG;
      end
      OPC_IMM: begin
        case (funct3)
          3'b001:  if (f7_base) cls = CL_IMM;
          3'b101:  if (f7_base || f7_alt) cls = CL_IMM;
          default: cls = CL_IMM;
        endcase
      end
      OPC_LOAD:   if (funct3 == F3_WORD) cls = CL_LOAD;
      OPC_STORE:  if (funct3 == F3_WORD) cls = CL_STORE;
      OPC_BRANCH: if (funct3[2:1] != 2'b01) cls = CL_BRANCH;
      OPC_JAL:    cls = CL_JAL;
      OPC_JALR:   if (funct3 == 3'b000) cls = CL_JALR;
      OPC_LUI:    cls = CL_LUI;
      OPC_AUIPC:  cls = CL_AUIPC;
      default:    cls = CL_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/rvdec_alu_ctl.sv
module rvdec_alu_ctl
  import rvdec_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            alt,
  input  logic            reg_form,
  output alu_sel_e        alu_op
);
  always_comb begin
    case (funct3)
      3'b000:  alu_op = (alt && reg_form) ? ALU_SUB : ALU_ADD;
      3'b001:  alu_op = ALU_SLL;
      3'b010:  alu_op = ALU_SLT;
      3'b011:  alu_op = ALU_SLTU;
      3'b100:  alu_op = ALU_XOR;
      3'b101:  alu_op = alt ? ALU_SRA : ALU_SRL;
      3'b110:  alu_op = ALU_OR;
      default: alu_op = ALU_AND;
    endcase
  end
endmodule

// File: rtl/rvdec_branch.sv
module rvdec_branch
  import rvdec_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            eq,
  input  logic            lt,
  output logic            taken,
  output logic            unsigned_cmp
);
  logic raw;
  always_comb begin
    case (funct3[2:1])
      2'b00:   raw = eq;
      default: raw = lt;
    endcase
  end
  assign taken        = raw ^ funct3[0];
  assign unsigned_cmp = (funct3[2:1] == 2'b11);
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [INSN_W-1:0]    insn,
  input  logic                 br_eq,
  input  logic                 br_lt,
  output logic                 pc_sel,
  output logic [IMM_SEL_W-1:0] imm_sel,
  output logic                 reg_we,
  output logic                 a_sel,
  output logic                 b_sel,
  output logic [ALU_SEL_W-1:0] alu_sel,
  output logic                 br_un,
  output logic                 mem_wr,
  output logic [WB_SEL_W-1:0]  wb_sel
);
  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic [F7_W-1:0]  f7;
  assign opc = insn[OPC_W-1:0];
  assign f3  = insn[14:12];
  assign f7  = insn[INSN_W-1:INSN_W-F7_W];

  insn_class_e cls;
  alu_sel_e    alu_op;
  logic        br_taken, br_unsigned;
  ctrl_t       c;

  rvdec_class u_class (.opcode(opc), .funct3(f3), .funct7(f7), .cls(cls));

  rvdec_alu_ctl u_alu (
    .funct3(f3), .alt(f7[5]), .reg_form(cls == CL_REG), .alu_op(alu_op)
  );

  rvdec_branch u_br (
    .funct3(f3), .eq(br_eq), .lt(br_lt),
    .taken(br_taken), .unsigned_cmp(br_unsigned)
  );

  always_comb begin
    c = CTRL_SAFE;
    case (cls)
      CL_REG: begin
        c.reg_we = 1'b1; c.alu = alu_op; c.wb = WB_ALU;
      end
      CL_IMM: begin
        c.reg_we = 1'b1; c.b_imm = 1'b1; c.alu = alu_op; c.wb = WB_ALU;
      end
      CL_LOAD: begin
        c.reg_we = 1'b1; c.b_imm = 1'b1; c.wb = WB_MEM;
      end
      CL_STORE: begin
        c.imm = IMM_S; c.b_imm = 1'b1; c.mem_wr = 1'b1; c.wb = WB_ALU;
      end
      CL_BRANCH: begin
        c.imm = IMM_B; c.a_pc = 1'b1; c.b_imm = 1'b1; c.wb = WB_ALU;
        c.pc_alu = br_taken; c.br_un = br_unsigned;
      end
      CL_JAL: begin
        c.imm = IMM_J; c.a_pc = 1'b1; c.b_imm = 1'b1; c.reg_we = 1'b1;
        c.wb = WB_PC4; c.pc_alu = 1'b1;
      end
      CL_JALR: begin
        c.b_imm = 1'b1; c.reg_we = 1'b1; c.wb = WB_PC4; c.pc_alu = 1'b1;
      end
      CL_LUI: begin
        c.imm = IMM_U; c.b_imm = 1'b1; c.alu = ALU_PASSB; c.reg_we = 1'b1;
        c.wb = WB_ALU;
      end
      CL_AUIPC: begin
        c.imm = IMM_U; c.a_pc = 1'b1; c.b_imm = 1'b1; c.reg_we = 1'b1;
        c.wb = WB_ALU;
      end
      default: c = CTRL_SAFE;
    endcase
  end

  assign pc_sel  = c.pc_alu;
  assign imm_sel = c.imm;
  assign reg_we  = c.reg_we;
  assign a_sel   = c.a_pc;
  assign b_sel   = c.b_imm;
  assign alu_sel = c.alu;
  assign br_un   = c.br_un;
  assign mem_wr  = c.mem_wr;
  assign wb_sel  = c.wb;

  always_comb begin
    if (!$isunknown({insn, br_eq, br_lt})) begin
      // R13
      we_store_excl_chk: assert (!(reg_we && mem_wr))
        else $error("register write and store both active");
      // R5
      store_scope_chk: assert (!mem_wr || (opc == OPC_STORE && b_sel))
        else $error("store outside store opcode");
      // R8
      unsigned_scope_chk: assert (!br_un || opc == OPC_BRANCH)
        else $error("unsigned compare outside branch");
      // R9
      link_redirect_chk: assert (wb_sel != WB_PC4 || (pc_sel && reg_we))
        else $error("link write-back without redirect");
      // R7
      redirect_src_chk: assert (!pc_sel || wb_sel == WB_PC4 || opc == OPC_BRANCH)
        else $error("redirect from non-control instruction");
    end
  end
endmodule

// File: tb/test_rvdec_ctrl.sv
module test_rvdec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = 32'h0;
  logic        br_eq = 1'b0, br_lt = 1'b0;
  logic        pc_sel, reg_we, a_sel, b_sel, br_un, mem_wr;
  logic [2:0]  imm_sel;
  logic [3:0]  alu_sel;
  logic [1:0]  wb_sel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rvdec_ctrl i_rvdec_ctrl (
    .insn(insn), .br_eq(br_eq), .br_lt(br_lt), .pc_sel(pc_sel),
    .imm_sel(imm_sel), .reg_we(reg_we), .a_sel(a_sel), .b_sel(b_sel),
    .alu_sel(alu_sel), .br_un(br_un), .mem_wr(mem_wr), .wb_sel(wb_sel)
  );

  // vector: {pc, imm[2:0], we, a, b, alu[3:0], un, mw, wb[1:0]}
  function automatic logic [3:0] alu_of(input logic [2:0] f3, input logic b5, input bit rform);
    case (f3)
      3'd0: return (b5 && rform) ? 4'd1 : 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      3'd5: return b5 ? 4'd7 : 4'd6;
      3'd6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [14:0] pack(input logic pc, input logic [2:0] im, input logic we,
      input logic a, input logic b, input logic [3:0] al, input logic un, input logic mw,
      input logic [1:0] wb);
    return {pc, im, we, a, b, al, un, mw, wb};
  endfunction

  function automatic logic [14:0] expect_of(input logic [31:0] w, input logic eq, input logic lt);
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    logic t;
    case (op)
      7'b0110011: if (f7 == 7'h00 || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5)))
        return pack(0, 0, 1, 0, 0, alu_of(f3, f7[5], 1), 0, 0, 1);
      7'b0010011: if ((f3 != 3'd1 && f3 != 3'd5) || (f3 == 3'd1 && f7 == 7'h00) ||
                      (f3 == 3'd5 && (f7 == 7'h00 || f7 == 7'h20)))
        return pack(0, 0, 1, 0, 1, alu_of(f3, f7[5], 0), 0, 0, 1);
      7'b0000011: if (f3 == 3'd2) return pack(0, 0, 1, 0, 1, 0, 0, 0, 0);
      7'b0100011: if (f3 == 3'd2) return pack(0, 1, 0, 0, 1, 0, 0, 1, 1);
      7'b1100011: if (f3 != 3'd2 && f3 != 3'd3) begin
        case (f3)
          3'd0: t = eq;
          3'd1: t = !eq;
          3'd4, 3'd6: t = lt;
          default: t = !lt;
        endcase
        return pack(t, 2, 0, 1, 1, 0, f3[2] & f3[1], 0, 1);
      end
      7'b1101111: return pack(1, 4, 1, 1, 1, 0, 0, 0, 2);
      7'b1100111: if (f3 == 3'd0) return pack(1, 0, 1, 0, 1, 0, 0, 0, 2);
      7'b0110111: return pack(0, 3, 1, 0, 1, 10, 0, 0, 1);
      7'b0010111: return pack(0, 3, 1, 1, 1, 0, 0, 0, 1);
      default: ;
    endcase
    return 15'h0;
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    logic [14:0] e = expect_of(w, 1'b0, 1'b0);
    if (e == 15'h0 && w[6:0] != 7'b1100011) return "R13 safe";
    case (w[6:0])
      7'b0110011: return "R1/R2 reg";
      7'b0010011: return "R3/R2 imm";
      7'b0000011: return "R4 load";
      7'b0100011: return "R5 store";
      7'b1100011: return (expect_of(w, 1, 1) == 15'h0 && expect_of(w, 0, 0) == 15'h0) ? "R13 safe" : "R6/R7/R8 branch";
      7'b1101111: return "R9 jal";
      7'b1100111: return "R10 jalr";
      7'b0110111: return "R11 lui";
      default:    return "R12 auipc";
    endcase
  endfunction

  task automatic apply_check(input logic [31:0] w, input logic eq, input logic lt, input string tag);
    logic [14:0] got, exp;
    @(negedge clk);
    insn = w; br_eq = eq; br_lt = lt;
    #1;
    got = {pc_sel, imm_sel, reg_we, a_sel, b_sel, alu_sel, br_un, mem_wr, wb_sel};
    exp = expect_of(w, eq, lt);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s insn=%h eq=%b lt=%b actual=%h expected=%h", tag, w, eq, lt, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] op);
    logic [31:0] r = $urandom;
    return {f7, r[24:15], f3, r[11:7], op};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R13 idle word: all zero
    apply_check(32'h0000_0000, 0, 0, "R13 reset-state zero word");
    // R1 R2 add/sub and sra/srl, illegal alt funct7 on xor
    apply_check(mk(7'h00, 3'd0, 7'b0110011), 0, 0, "R1 add");
    apply_check(mk(7'h20, 3'd0, 7'b0110011), 0, 0, "R2 sub");
    apply_check(mk(7'h20, 3'd5, 7'b0110011), 0, 0, "R2 sra");
    apply_check(mk(7'h20, 3'd4, 7'b0110011), 0, 0, "R13 reg alt xor");
    // R3 addi with bit30 set stays ADD; shift legality
    apply_check(mk(7'h20, 3'd0, 7'b0010011), 0, 0, "R3 addi bit30");
    apply_check(mk(7'h20, 3'd5, 7'b0010011), 0, 0, "R3 srai");
    apply_check(mk(7'h20, 3'd1, 7'b0010011), 0, 0, "R13 bad slli");
    apply_check(mk(7'h01, 3'd5, 7'b0010011), 0, 0, "R13 bad srli");
    apply_check(mk(7'h33, 3'd2, 7'b0000011), 0, 0, "R4 lw");
    apply_check(mk(7'h33, 3'd0, 7'b0000011), 0, 0, "R13 lb");
    apply_check(mk(7'h11, 3'd2, 7'b0100011), 1, 1, "R5 sw");
    apply_check(mk(7'h11, 3'd1, 7'b0100011), 0, 0, "R13 sh");
    // R6 R7 R8 every branch funct3 against every flag pair
    for (int f = 0; f < 8; f++)
      for (int fl = 0; fl < 4; fl++)
        apply_check(mk(7'h05, f[2:0], 7'b1100011), fl[1], fl[0], "R6/R7/R8 branch sweep");
    apply_check(mk(7'h7f, 3'd3, 7'b1101111), 1, 0, "R9 jal");
    apply_check(mk(7'h00, 3'd0, 7'b1100111), 0, 1, "R10 jalr");
    apply_check(mk(7'h00, 3'd1, 7'b1100111), 0, 0, "R13 jalr f3");
    apply_check(mk(7'h2a, 3'd6, 7'b0110111), 0, 0, "R11 lui");
    apply_check(mk(7'h2a, 3'd6, 7'b0010111), 0, 0, "R12 auipc");
    apply_check(32'h0000_000F, 0, 0, "R13 fence-like");
    // R14 flag-only change moves pc_sel without a clock edge
    begin
      logic [31:0] bw = mk(7'h00, 3'd0, 7'b1100011);
      apply_check(bw, 0, 0, "R14 flag low");
      @(posedge clk); #1;
      br_eq = 1'b1; #1;
      checks++;
      if (pc_sel !== 1'b1) begin
        fails++;
        $display("FAIL R14 pc_sel actual=%b expected=1", pc_sel);
      end
    end
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [6:0] ops [9] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
                              7'b1100011, 7'b1101111, 7'b1100111, 7'b0110111, 7'b0010111};
      int k = $urandom % 11;
      logic [6:0] f7 = ($urandom % 3 == 0) ? 7'h20 : (($urandom % 4 == 0) ? 7'($urandom) : 7'h00);
      if (k < 9) w = mk(f7, 3'($urandom), ops[k]);
      else w = $urandom;
      apply_check(w, 1'($urandom), 1'($urandom), tag_of(w));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule